// File: doc/BRIEF.md
# Dusk-Triggered Lamp Duration Timer

This block switches a lamp relay on when nightfall is detected and keeps it on for a fixed number of half-hour intervals. Everything runs from one fast crystal clock. A free-running prescaler makes a slow sample tick, and on that tick the synchronised light-comparator level is captured. A second free-running divider gives a one-second enable pulse. Two cascaded interval stages turn that pulse into a half-hour tick, and a period counter then counts half-hour ticks.

A small state machine has three states. `S_ARMED` waits for darkness with the relay off. `S_LAMP` drives the relay and lets the interval stages count. `S_SPENT` is entered when the period ends: the relay is off and the interval stages are held clear until daylight comes back. Its transitions are:

- ARMED→LAMP on a sampled dark level.
- LAMP→SPENT when the period counter wraps.
- Any state→ARMED whenever the sampled level reads daylight. This returns the timer to its armed state.

The interval stages are cleared by power-on reset, by sampled daylight, or by any state other than `S_LAMP`. They therefore all leave reset together on one edge. The sensor prescaler and the one-second divider are cleared only by power-on reset, so the sensor keeps being sampled after the period ends. All divider ratios are parameters, so a simulation can use short periods.

Top module: `dusk_lamp_timer`

## Requirements
- R1: While `rst_por` is high, `relay_on`, `tick_1hz` and `tick_30min` are low. After reset the sampled level reads daylight and the state is `S_ARMED`.
- R2: `tick_1hz` is a one-cycle pulse exactly every `CLK_DIV_1HZ` cycles, in every state, with no break after reset.
- R3: `sensor_bright` (1 = daylight, 0 = dark) is only used after two synchroniser flops and a capture register. That register is enabled once every `2**PRE_BITS * DECADE_DIV` cycles. A dark level held steady makes `relay_on` rise between 3 and that sample period plus 4 cycles after the level changes (ARMED→LAMP).
- R4: Once on, `relay_on` stays high for exactly `PERIOD_INTERVALS` pulses of `tick_30min`, and falls on the cycle after the last of them (LAMP→SPENT). The on-time lies between `(N-1)*CLK_DIV_1HZ` and `N*CLK_DIV_1HZ+1` cycles, where N = `STAGE_A_DIV*STAGE_B_DIV*PERIOD_INTERVALS`.
- R5: After the period ends, while darkness persists, `relay_on` stays low and `tick_30min` stays silent, but `tick_1hz` keeps pulsing.
- R6: Sampled daylight forces `relay_on` low within the sampling latency of R3, whatever the interval count.
- R7: Daylight followed by darkness re-arms the timer (SPENT→ARMED→LAMP), and a second full period follows.
- R8: A `tick_30min` pulse marks every `STAGE_A_DIV*STAGE_B_DIV` counted seconds.
- R9: `tick_30min` pulses only while `relay_on` is high. It never pulses during sampled daylight or in `S_SPENT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock, the only clock domain |
| rst_por | input | 1 | Power-on reset, active high, synchronous |
| sensor_bright | input | 1 | Raw light-comparator level, 1 = daylight |
| relay_on | output | 1 | Lamp relay drive |
| tick_1hz | output | 1 | One-cycle pulse each second |
| tick_30min | output | 1 | One-cycle pulse at each counted half-hour interval |

## Verification
The hardest situation to reach is a period that has expired while darkness continues. To reach it, the dark level must be held for the whole on-time and then some. Only in that window can the bench see that the one-second chain and the sampler keep running while the interval stages stay frozen. Small divider parameters make the full period about a hundred cycles. Directed runs hold darkness past the period end, insert daylight in the middle of a period, and re-arm afterwards. Seeded random bright and dark segments then land the change points at every phase of the sample prescaler, and outcomes are judged only outside the latency windows where the expected relay state is unambiguous.

// File: rtl/dusk_pkg.sv
package dusk_pkg;

    typedef enum logic [1:0] {
        S_ARMED = 2'd0,
        S_LAMP  = 2'd1,
        S_SPENT = 2'd2
    } lamp_state_t;

endpackage

// File: rtl/dusk_mod_counter.sv
// Modulo-MOD enable counter with synchronous clear; wrap is a one-cycle
// pulse on the enabled cycle in which the count returns to zero.
module dusk_mod_counter #(
    parameter int MOD = 10
) (
    input  logic clk,
    input  logic clr,
    input  logic en,
    output logic wrap
);
    localparam int W = (MOD > 2) ? $clog2(MOD) : 1;
    localparam logic [W-1:0] LAST = W'(MOD - 1);

    logic [W-1:0] cnt;

    assign wrap = en && !clr && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= wrap ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dusk_sensor_front.sv
// Two-flop synchroniser, free-running sample prescaler and capture register.
module dusk_sensor_front #(
    parameter int PRE_BITS   = 14,
    parameter int DECADE_DIV = 10
) (
    input  logic clk,
    input  logic rst_por,
    input  logic sensor_bright,
    output logic day_seen
);
    localparam int PRE_MOD = 1 << PRE_BITS;

    logic sync_a, sync_b;
    logic pre_wrap, sample_tick;

    always_ff @(posedge clk) begin
        if (rst_por) begin
            sync_a <= 1'b1;
            sync_b <= 1'b1;
        end else begin
            sync_a <= sensor_bright;
            sync_b <= sync_a;
        end
    end

    dusk_mod_counter #(.MOD(PRE_MOD)) u_prescale (
        .clk  (clk),
        .clr  (rst_por),
        .en   (1'b1),
        .wrap (pre_wrap)
    );

    dusk_mod_counter #(.MOD(DECADE_DIV)) u_decade (
        .clk  (clk),
        .clr  (rst_por),
        .en   (pre_wrap),
        .wrap (sample_tick)
    );

    always_ff @(posedge clk) begin
        if (rst_por) begin
            day_seen <= 1'b1;
        end else if (sample_tick) begin
            day_seen <= sync_b;
        end
    end
endmodule

// File: rtl/dusk_interval_chain.sv
// Free-running one-second divider feeding clearable interval stages and
// a period counter.
module dusk_interval_chain #(
    parameter int CLK_DIV_1HZ      = 2457600,
    parameter int STAGE_A_DIV      = 60,
    parameter int STAGE_B_DIV      = 30,
    parameter int PERIOD_INTERVALS = 10
) (
    input  logic clk,
    input  logic rst_por,
    input  logic hold,
    output logic sec_tick,
    output logic interval_tick,
    output logic period_done
);
    localparam int NUM_STAGES = 2;

    function automatic int stage_div(input int idx);
        return (idx == 0) ? STAGE_A_DIV : STAGE_B_DIV;
    endfunction

    logic [NUM_STAGES:0] stage_en;

    dusk_mod_counter #(.MOD(CLK_DIV_1HZ)) u_sec (
        .clk  (clk),
        .clr  (rst_por),
        .en   (1'b1),
        .wrap (sec_tick)
    );

    assign stage_en[0] = sec_tick;

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        dusk_mod_counter #(.MOD(stage_div(g))) u_stage (
            .clk  (clk),
            .clr  (hold),
            .en   (stage_en[g]),
            .wrap (stage_en[g+1])
        );
    end

    assign interval_tick = stage_en[NUM_STAGES];

    dusk_mod_counter #(.MOD(PERIOD_INTERVALS)) u_period (
        .clk  (clk),
        .clr  (hold),
        .en   (interval_tick),
        .wrap (period_done)
    );
endmodule

// File: rtl/dusk_lamp_timer.sv
module dusk_lamp_timer
    import dusk_pkg::*;
#(
    parameter int PRE_BITS         = 14,
    parameter int DECADE_DIV       = 10,
    parameter int CLK_DIV_1HZ      = 2457600,
    parameter int STAGE_A_DIV      = 60,
    parameter int STAGE_B_DIV      = 30,
    parameter int PERIOD_INTERVALS = 10
) (
    input  logic clk,
    input  logic rst_por,
    input  logic sensor_bright,
    output logic relay_on,
    output logic tick_1hz,
    output logic tick_30min
);
    lamp_state_t state, state_nx;
    logic day_seen;
    logic hold_intervals;
    logic period_done;

    dusk_sensor_front #(
        .PRE_BITS   (PRE_BITS),
        .DECADE_DIV (DECADE_DIV)
    ) u_front (
        .clk           (clk),
        .rst_por       (rst_por),
        .sensor_bright (sensor_bright),
        .day_seen      (day_seen)
    );

    // Master clear for the interval stages only.
    assign hold_intervals = rst_por || day_seen || (state != S_LAMP);

    dusk_interval_chain #(
        .CLK_DIV_1HZ      (CLK_DIV_1HZ),
        .STAGE_A_DIV      (STAGE_A_DIV),
        .STAGE_B_DIV      (STAGE_B_DIV),
        .PERIOD_INTERVALS (PERIOD_INTERVALS)
    ) u_chain (
        .clk           (clk),
        .rst_por       (rst_por),
        .hold          (hold_intervals),
        .sec_tick      (tick_1hz),
        .interval_tick (tick_30min),
        .period_done   (period_done)
    );

    always_ff @(posedge clk) begin
        if (rst_por) begin
            state <= S_ARMED;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        if (day_seen) begin
            state_nx = S_ARMED;
        end else begin
            unique case (state)
                S_ARMED: state_nx = S_LAMP;
                S_LAMP:  state_nx = period_done ? S_SPENT : S_LAMP;
                S_SPENT: state_nx = S_SPENT;
                default: state_nx = S_ARMED;
            endcase
        end
    end

    always_comb begin
        relay_on = (state == S_LAMP);
    end
endmodule

// File: rtl/dusk_lamp_timer_chk.sv
module dusk_lamp_timer_chk #(
    parameter int CLK_DIV_1HZ      = 2457600,
    parameter int PERIOD_INTERVALS = 10
) (
    input logic clk,
    input logic rst_por,
    input logic relay_on,
    input logic tick_1hz,
    input logic tick_30min,
    input logic day_seen
);
    localparam int GW = $clog2(CLK_DIV_1HZ + 1);
    localparam int PW = $clog2(PERIOD_INTERVALS + 1);

    logic [GW-1:0] gap;
    logic [PW-1:0] on_ticks;

    always_ff @(posedge clk) begin
        if (rst_por || tick_1hz) gap <= '0;
        else                     gap <= gap + 1'b1;
        if (rst_por || !relay_on) on_ticks <= '0;
        else if (tick_30min)      on_ticks <= on_ticks + 1'b1;
    end

    // R1
    por_quiet_chk: assert property (@(posedge clk)
        rst_por |=> (!relay_on && !tick_30min));

    // R2
    sec_spacing_chk: assert property (@(posedge clk) disable iff (rst_por)
        tick_1hz |-> (gap == GW'(CLK_DIV_1HZ - 1)));

    // R2
    sec_gap_chk: assert property (@(posedge clk) disable iff (rst_por)
        gap < GW'(CLK_DIV_1HZ));

    // R4
    period_limit_chk: assert property (@(posedge clk) disable iff (rst_por)
        (relay_on && tick_30min) |-> (on_ticks < PW'(PERIOD_INTERVALS)));

    // R4
    relay_drop_cause_chk: assert property (@(posedge clk) disable iff (rst_por)
        $fell(relay_on) |-> ($past(tick_30min) || $past(day_seen)));

    // R6
    daylight_off_chk: assert property (@(posedge clk) disable iff (rst_por)
        day_seen |=> !relay_on);

    // R9
    interval_gated_chk: assert property (@(posedge clk) disable iff (rst_por)
        tick_30min |-> relay_on);
endmodule

bind dusk_lamp_timer dusk_lamp_timer_chk #(
    .CLK_DIV_1HZ      (CLK_DIV_1HZ),
    .PERIOD_INTERVALS (PERIOD_INTERVALS)
) u_chk (
    .clk        (clk),
    .rst_por    (rst_por),
    .relay_on   (relay_on),
    .tick_1hz   (tick_1hz),
    .tick_30min (tick_30min),
    .day_seen   (day_seen)
);

// File: tb/dusk_lamp_timer_test.sv
module dusk_lamp_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int PRE_BITS   = 2;
    localparam int DECADE_DIV = 2;
    localparam int SEC_DIV    = 5;
    localparam int STG_A      = 3;
    localparam int STG_B      = 2;
    localparam int PERIODS    = 4;
    localparam int SP         = (1 << PRE_BITS) * DECADE_DIV;
    localparam int NSEC       = STG_A * STG_B * PERIODS;
    localparam int IV_CYC     = STG_A * STG_B * SEC_DIV;

    logic clk = 1'b0;
    logic rst_por = 1'b1;
    logic sensor_bright = 1'b1;
    logic relay_on, tick_1hz, tick_30min;

    int checks = 0;
    int fails = 0;
    int t1_cnt = 0;
    int t30_cnt = 0;
    int gap = 0;
    bit gap_valid = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dusk_lamp_timer #(
        .PRE_BITS         (PRE_BITS),
        .DECADE_DIV       (DECADE_DIV),
        .CLK_DIV_1HZ      (SEC_DIV),
        .STAGE_A_DIV      (STG_A),
        .STAGE_B_DIV      (STG_B),
        .PERIOD_INTERVALS (PERIODS)
    ) uut (
        .clk           (clk),
        .rst_por       (rst_por),
        .sensor_bright (sensor_bright),
        .relay_on      (relay_on),
        .tick_1hz      (tick_1hz),
        .tick_30min    (tick_30min)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit in_win(input int v, input int lo, input int hi);
        return (v >= lo) && (v <= hi);
    endfunction

    // 1 = on, 0 = off, 2 = ambiguous, for darkness held e cycles from armed
    function automatic int exp_relay(input int e);
        if (e < 3) return 0;
        if (e >= SP + 4 && e <= (NSEC - 1) * SEC_DIV + 3) return 1;
        if (e >= SP + 6 + NSEC * SEC_DIV) return 0;
        return 2;
    endfunction

    // continuous port monitor, sampled between edges
    always @(negedge clk) begin
        if (rst_por) begin
            gap_valid = 1'b0;
            gap = 0;
        end else begin
            if (tick_1hz) begin
                t1_cnt++;
                if (gap_valid) chk(gap == SEC_DIV, "R2 tick_1hz spacing", gap, SEC_DIV);
                gap = 1;
                gap_valid = 1'b1;
            end else begin
                gap++;
            end
            if (tick_30min) begin
                t30_cnt++;
                chk(relay_on, "R9 tick_30min while relay off", relay_on, 1);
            end
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_relay(input bit target, input int max_c, output int lat);
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (relay_on !== target && lat < max_c);
    endtask

    task automatic full_period(input string tag);
        int lat, dur, t30_base, t30_iv, i_prev;
        sensor_bright = 1'b0;
        wait_relay(1'b1, SP + 20, lat);
        chk(in_win(lat, 3, SP + 4), {tag, " dark-to-relay latency"}, lat, SP + 3);
        t30_base = t30_cnt;
        i_prev = t30_cnt;
        dur = 0;
        t30_iv = 0;
        while (relay_on && dur < NSEC * SEC_DIV + 50) begin
            @(negedge clk);
            dur++;
            if (t30_cnt != i_prev) begin
                i_prev = t30_cnt;
                t30_iv++;
            end
        end
        chk(in_win(dur, (NSEC - 1) * SEC_DIV, NSEC * SEC_DIV + 1),
            {tag, " R4 on-time cycles"}, dur, NSEC * SEC_DIV);
        chk(t30_cnt - t30_base == PERIODS, {tag, " R4 tick_30min count"},
            t30_cnt - t30_base, PERIODS);
        chk(in_win(dur, (t30_iv) * IV_CYC - SEC_DIV, t30_iv * IV_CYC + 1),
            {tag, " R8 interval length"}, dur, t30_iv * IV_CYC);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int lat, t1_base, t30_base;
        void'($urandom(32'd20241));

        // R1 reset state
        cycles(4);
        chk(!relay_on && !tick_1hz && !tick_30min, "R1 outputs in reset",
            {relay_on, tick_1hz, tick_30min}, 0);
        sensor_bright = 1'b0;
        cycles(SP + 6);
        chk(!relay_on, "R1 dark during reset ignored", relay_on, 0);
        sensor_bright = 1'b1;
        rst_por = 1'b0;
        cycles(SP * 3);
        chk(!relay_on, "R1 armed with daylight", relay_on, 0);

        // R3, R4, R8 first full period
        full_period("R3 first");

        // R5 period over, still dark
        t1_base = t1_cnt;
        t30_base = t30_cnt;
        for (int i = 0; i < 3 * IV_CYC; i++) begin
            @(negedge clk);
            if (relay_on) begin
                chk(1'b0, "R5 relay stays off after period", 1, 0);
                break;
            end
        end
        chk(t30_cnt == t30_base, "R5 tick_30min silent when spent", t30_cnt - t30_base, 0);
        chk(in_win(t1_cnt - t1_base, 3 * IV_CYC / SEC_DIV - 1, 3 * IV_CYC / SEC_DIV + 1),
            "R5 tick_1hz free-runs when spent", t1_cnt - t1_base, 3 * IV_CYC / SEC_DIV);

        // R7 re-arm after daylight
        sensor_bright = 1'b1;
        cycles(SP * 2 + 6);
        chk(!relay_on, "R7 off in daylight before re-arm", relay_on, 0);
        full_period("R7 re-armed");

        // R6 daylight in mid-period
        sensor_bright = 1'b1;
        cycles(SP * 2 + 6);
        sensor_bright = 1'b0;
        wait_relay(1'b1, SP + 20, lat);
        chk(in_win(lat, 3, SP + 4), "R3 latency mid test", lat, SP + 3);
        cycles(2 * IV_CYC);
        chk(relay_on, "R6 still on mid-period", relay_on, 1);
        sensor_bright = 1'b1;
        wait_relay(1'b0, SP + 20, lat);
        chk(in_win(lat, 3, SP + 4), "R6 daylight forces off", lat, SP + 3);
        t30_base = t30_cnt;
        cycles(2 * IV_CYC);
        chk(t30_cnt == t30_base && !relay_on, "R9 no interval ticks in daylight",
            t30_cnt - t30_base, 0);

        // random segments, every prescaler phase
        for (int s = 0; s < 24; s++) begin
            int bright_len, dark_len, e;
            bright_len = SP + 8 + int'($urandom_range(40));
            dark_len = int'($urandom_range(NSEC * SEC_DIV + 40));
            sensor_bright = 1'b1;
            cycles(bright_len);
            chk(!relay_on, "R6 random daylight segment", relay_on, 0);
            sensor_bright = 1'b0;
            for (e = 1; e <= dark_len; e++) begin
                @(negedge clk);
                if (exp_relay(e) != 2 && relay_on != exp_relay(e)[0]) begin
                    chk(1'b0, "R7 random dark segment relay", relay_on, exp_relay(e));
                    break;
                end
            end
            if (exp_relay(dark_len) != 2)
                chk(relay_on == exp_relay(dark_len)[0], "R4 random segment end state",
                    relay_on, exp_relay(dark_len));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule